// File: doc/BRIEF.md
# Register Bus-Transfer Enable Decoder

This block turns a compact 4-bit transfer code held in the control word register into gate controls for a bank of general registers that share two internal buses, A and B. The code names up to two simultaneous transfers involving the two operand registers of the current instruction, called X and Y here. The register numbers for X and Y come from the static instruction register. Each number is expanded to a one-hot select, and the code is expanded into a set of bus-transfer lines. Each register's enables are formed from the one-hot selects and the transfer lines, and are captured in an output register.

Each register gets four controls: a load strobe, a load-source select (bus A or bus B), a drive-onto-A enable and a drive-onto-B enable. The output register is updated on every clock, so the enables apply in the cycle after the code and register numbers are presented. Only legal pairs of transfers are encodable. Every unassigned code produces no activity at all.

Top module: `regxfer_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `load_en`, `load_from_a`, `drive_a` and `drive_b` is cleared to 0.
- R2: The outputs after a rising edge reflect `xfer_code`, `x_idx` and `y_idx` as sampled at that edge, which gives one cycle of latency. Inputs that change every cycle each produce their own result.
- R3: Code meanings (written as bits 3..0). 0000 means no transfer. 0001 loads X from B. 0010 drives Y onto A. 0011 drives X onto A. 0100 loads Y from B. 0110 drives X onto B and loads Y from B. 0111 drives X onto A and loads Y from B. 1001 drives Y onto B and loads X from B. 1011 drives X onto A and Y onto B. 1101 loads X from B and loads Y from A.
- R4: Register numbers are decoded one-hot. Bit i of each output vector can only be set through `x_idx == i` or `y_idx == i`.
- R5: Bit i of `load_en` is set when the code loads X and `x_idx == i`, or when the code loads Y and `y_idx == i`.
- R6: Bit i of `load_from_a` is set only when the code is 1101 and `y_idx == i`. A register that is loaded and does not meet this condition takes its value from bus B (`load_from_a` = 0).
- R7: Bit i of `drive_a` is set when (the code drives X onto A and `x_idx == i`) or (the code drives Y onto A and `y_idx == i`).
- R8: Bit i of `drive_b` is set when (the code drives X onto B and `x_idx == i`) or (the code drives Y onto B and `y_idx == i`).
- R9: The codes 0101, 1000, 1010, 1100, 1110 and 1111 set no output bit.
- R10: When `x_idx == y_idx` and the code loads one operand while the other drives a bus, the shared register has both its load and its drive enables set.
- R11: At most one register drives bus A and at most one register drives bus B in any cycle. A set `load_from_a` bit always has its `load_en` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xfer_code | input | 4 | Transfer code from the control word register |
| x_idx | input | $clog2(NREGS) | X register number from the instruction |
| y_idx | input | $clog2(NREGS) | Y register number from the instruction |
| load_en | output | NREGS | Per-register load strobe |
| load_from_a | output | NREGS | Per-register load source: 1 = bus A, 0 = bus B |
| drive_a | output | NREGS | Per-register drive-onto-A enable |
| drive_b | output | NREGS | Per-register drive-onto-B enable |

## Verification
The bench applies all sixteen codes, so a decoder that treats an unassigned pattern as a neighbouring legal code would show a stray load or drive bit. It sweeps every X and Y number under codes that use both operands. A swapped or shifted one-hot decode would then enable the wrong register, and so would a decoder that mixes up which operand owns which transfer. It also names the same register as X and Y under codes that load one operand and drive with the other. A merge that lets one enable mask the other would lose either the load or the drive. Back-to-back changes of inputs catch results that are registered too late or too early.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

    // Transfer lines produced from the 4-bit code
    typedef struct packed {
        logic x_to_a;   // X drives bus A
        logic y_to_a;   // Y drives bus A
        logic x_to_b;   // X drives bus B
        logic y_to_b;   // Y drives bus B
        logic a_to_y;   // Y loads from bus A
        logic b_to_x;   // X loads from bus B
        logic b_to_y;   // Y loads from bus B
    } xfer_lines_t;

    localparam logic [3:0] XC_NONE      = 4'b0000;
    localparam logic [3:0] XC_LDX_B     = 4'b0001;
    localparam logic [3:0] XC_Y_A       = 4'b0010;
    localparam logic [3:0] XC_X_A       = 4'b0011;
    localparam logic [3:0] XC_LDY_B     = 4'b0100;
    localparam logic [3:0] XC_XB_LDY_B  = 4'b0110;
    localparam logic [3:0] XC_XA_LDY_B  = 4'b0111;
    localparam logic [3:0] XC_YB_LDX_B  = 4'b1001;
    localparam logic [3:0] XC_XA_YB     = 4'b1011;
    localparam logic [3:0] XC_LDX_B_LDY_A = 4'b1101;

    function automatic xfer_lines_t decode_xfer(input logic [3:0] code);
        xfer_lines_t l;
        l = '0;
        case (code)
            XC_LDX_B:       l.b_to_x = 1'b1;
            XC_Y_A:         l.y_to_a = 1'b1;
            XC_X_A:         l.x_to_a = 1'b1;
            XC_LDY_B:       l.b_to_y = 1'b1;
            XC_XB_LDY_B:    begin l.x_to_b = 1'b1; l.b_to_y = 1'b1; end
            XC_XA_LDY_B:    begin l.x_to_a = 1'b1; l.b_to_y = 1'b1; end
            XC_YB_LDX_B:    begin l.y_to_b = 1'b1; l.b_to_x = 1'b1; end
            XC_XA_YB:       begin l.x_to_a = 1'b1; l.y_to_b = 1'b1; end
            XC_LDX_B_LDY_A: begin l.b_to_x = 1'b1; l.a_to_y = 1'b1; end
            default:        l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/regxfer_onehot.sv
module regxfer_onehot #(
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic [IDXW-1:0]  idx,
    output logic [NREGS-1:0] sel
);
    for (genvar i = 0; i < NREGS; i++) begin : g_sel
        assign sel[i] = (idx == IDXW'(i));
    end

    always_comb begin
        assert ($onehot0(sel)); // R4
    end
endmodule

// File: rtl/regxfer_lines.sv
module regxfer_lines
    import regxfer_pkg::*;
(
    input  logic [3:0]  code,
    output xfer_lines_t lines
);
    always_comb begin
        lines = decode_xfer(code);
    end

    // each bus has at most one source operand
    always_comb begin
        assert (!(lines.x_to_a && lines.y_to_a)); // R11
        assert (!(lines.x_to_b && lines.y_to_b)); // R11
    end
endmodule

// File: rtl/regxfer_merge.sv
module regxfer_merge
    import regxfer_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  xfer_lines_t      lines,
    input  logic [NREGS-1:0] xsel,
    input  logic [NREGS-1:0] ysel,
    output logic [NREGS-1:0] load,
    output logic [NREGS-1:0] src_a,
    output logic [NREGS-1:0] drv_a,
    output logic [NREGS-1:0] drv_b
);
    logic load_x, load_y;

    always_comb begin
        load_x = lines.b_to_x;
        load_y = lines.a_to_y | lines.b_to_y;
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        assign load[i]  = (load_x & xsel[i]) | (load_y & ysel[i]);
        assign src_a[i] = lines.a_to_y & ysel[i];
        assign drv_a[i] = (lines.x_to_a & xsel[i]) | (lines.y_to_a & ysel[i]);
        assign drv_b[i] = (lines.x_to_b & xsel[i]) | (lines.y_to_b & ysel[i]);
    end

    always_comb begin
        assert ((src_a & ~load) == '0); // R6
    end
endmodule

// File: rtl/regxfer_decoder.sv
module regxfer_decoder
    import regxfer_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       xfer_code,
    input  logic [IDXW-1:0]  x_idx,
    input  logic [IDXW-1:0]  y_idx,
    output logic [NREGS-1:0] load_en,
    output logic [NREGS-1:0] load_from_a,
    output logic [NREGS-1:0] drive_a,
    output logic [NREGS-1:0] drive_b
);
    xfer_lines_t      lines;
    logic [NREGS-1:0] xsel, ysel;
    logic [NREGS-1:0] ld_c, sa_c, da_c, db_c;

    regxfer_onehot #(.NREGS(NREGS)) u_xdec (.idx(x_idx), .sel(xsel));
    regxfer_onehot #(.NREGS(NREGS)) u_ydec (.idx(y_idx), .sel(ysel));
    regxfer_lines u_lines (.code(xfer_code), .lines(lines));
    regxfer_merge #(.NREGS(NREGS)) u_merge (
        .lines(lines), .xsel(xsel), .ysel(ysel),
        .load(ld_c), .src_a(sa_c), .drv_a(da_c), .drv_b(db_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_en     <= '0;
            load_from_a <= '0;
            drive_a     <= '0;
            drive_b     <= '0;
        end else begin
            load_en     <= ld_c;
            load_from_a <= sa_c;
            drive_a     <= da_c;
            drive_b     <= db_c;
        end
    end

    logic code_unused;
    always_comb begin
        code_unused = (xfer_code == 4'b0101) || (xfer_code == 4'b1000) ||
                      (xfer_code == 4'b1010) || (xfer_code == 4'b1100) ||
                      (xfer_code == 4'b1110) || (xfer_code == 4'b1111);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (load_en == '0 && drive_a == '0 && drive_b == '0 && load_from_a == '0)); // R1
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
        code_unused |=> (load_en == '0 && drive_a == '0 && drive_b == '0)); // R9
    AST_BUS_A_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_a)); // R11
    AST_BUS_B_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive_b)); // R11
    AST_LOAD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $countones(load_en) <= 2); // R5
    AST_SRC_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load_from_a & ~load_en) == '0); // R6
    AST_SAME_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (x_idx == y_idx && xfer_code == 4'b0110) |=> (load_en != '0 && drive_b == load_en)); // R10
endmodule

// File: tb/regxfer_decoder_test.sv
module regxfer_decoder_test;
    localparam int N = 8;
    localparam int W = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]   code = '0;
    logic [W-1:0] xi = '0, yi = '0;
    logic [N-1:0] ld, sa, da, db;

    always #5 clk = ~clk;

    regxfer_decoder #(.NREGS(N)) uut (
        .clk(clk), .rst(rst), .xfer_code(code), .x_idx(xi), .y_idx(yi),
        .load_en(ld), .load_from_a(sa), .drive_a(da), .drive_b(db)
    );

    typedef struct {
        logic [N-1:0] ld, sa, da, db;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    function automatic exp_t model(logic [3:0] c, int x, int y, string tag);
        exp_t e;
        bit xa = 0, ya = 0, xb = 0, yb = 0, lx = 0, ly = 0, ly_a = 0;
        case (c)
            4'b0001: lx = 1;
            4'b0010: ya = 1;
            4'b0011: xa = 1;
            4'b0100: ly = 1;
            4'b0110: begin xb = 1; ly = 1; end
            4'b0111: begin xa = 1; ly = 1; end
            4'b1001: begin yb = 1; lx = 1; end
            4'b1011: begin xa = 1; yb = 1; end
            4'b1101: begin lx = 1; ly = 1; ly_a = 1; end
            default: ;
        endcase
        e.ld = '0; e.sa = '0; e.da = '0; e.db = '0;
        if (lx) e.ld[x] = 1'b1;
        if (ly) e.ld[y] = 1'b1;
        if (ly_a) e.sa[y] = 1'b1;
        if (xa) e.da[x] = 1'b1;
        if (ya) e.da[y] = 1'b1;
        if (xb) e.db[x] = 1'b1;
        if (yb) e.db[y] = 1'b1;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(logic [3:0] c, int x, int y, string tag);
        @(negedge clk);
        code = c; xi = W'(x); yi = W'(y);
        q.push_back(model(c, x, y, tag));
    endtask

    // monitor: compares one result per cycle, after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ld !== e.ld || sa !== e.sa || da !== e.da || db !== e.db) begin
                    errors++;
                    $display("FAIL %s: got ld=%b sa=%b da=%b db=%b exp ld=%b sa=%b da=%b db=%b",
                             e.tag, ld, sa, da, db, e.ld, e.sa, e.da, e.db);
                end
            end
        end
    end

    initial begin
        // R1: reset clears outputs even with a busy code applied
        code = 4'b0111; xi = 3'd1; yi = 3'd2;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (ld !== '0 || sa !== '0 || da !== '0 || db !== '0) begin
            errors++;
            $display("FAIL R1: got ld=%b sa=%b da=%b db=%b exp all zero", ld, sa, da, db);
        end
        @(negedge clk);
        rst = 1'b0;

        // R3 and R9: every code with distinct registers
        for (int c = 0; c < 16; c++) begin
            bit unused = (c == 5 || c == 8 || c == 10 || c == 12 || c == 14 || c == 15);
            drive(4'(c), 2, 5, unused ? "R9" : "R3");
        end
        // R4 R7 R8: sweep register numbers with two-operand drives
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++)
                if (x != y) drive(4'b1011, x, y, "R4_R7_R8");
        // R5: load lines on each register
        for (int r = 0; r < N; r++) begin
            drive(4'b0100, 0, r, "R5");
            drive(4'b0001, r, 7 - r, "R5");
        end
        // R6: load source select
        for (int r = 0; r < N; r++) drive(4'b1101, (r + 3) % N, r, "R6");
        drive(4'b0111, 4, 6, "R6");
        // R7: Y onto A
        for (int r = 0; r < N; r++) drive(4'b0010, 0, r, "R7");
        // R8: X onto B and Y onto B
        for (int r = 0; r < N; r++) begin
            drive(4'b0110, r, (r + 1) % N, "R8");
            drive(4'b1001, (r + 2) % N, r, "R8");
        end
        // R10: same register as X and Y
        for (int r = 0; r < N; r++) begin
            drive(4'b0110, r, r, "R10");
            drive(4'b0111, r, r, "R10");
            drive(4'b1001, r, r, "R10");
            drive(4'b1101, r, r, "R10");
        end
        // R2: alternating back-to-back inputs
        for (int k = 0; k < 12; k++) drive((k % 2) ? 4'b0011 : 4'b0000, k % N, 0, "R2");
        // R9: unused codes with same and different registers
        drive(4'b1111, 3, 3, "R9");
        drive(4'b1000, 1, 6, "R9");
        drive(4'b0000, 0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule